// File: doc/BRIEF.md
# Cascaded Dual Interrupt Controller

This block collects sixteen interrupt request lines and presents one interrupt to a host processor. Two identical eight-input priority controllers do the work. The primary controller takes lines 0 to 7. The secondary controller takes lines 8 to 15, and its interrupt output is ORed into primary input 2, which is the cascade input. Each controller has these registers:

- a request register;
- a mask register;
- an in-service register;
- a vector base;
- a rotation offset that moves the top-priority position;
- a per-input choice between edge and level triggering.

The host raises a one-cycle acknowledge. During that cycle the block resolves the winning request across both controllers and shows the 8-bit vector on `vec_out`. At the clock edge that ends the cycle, the in-service bits are set. If nothing can be resolved, the block returns the controller's base with index 7, which marks the vector as spurious. Configuration uses a plain register write with a unit-select bit. Software ends a service routine by pulsing an end-of-service strobe that names a unit and an input.

Top module: `cascade_intc`

## Requirements
- R1: After reset, `host_int` is low, every input is masked, both vector bases are 0 and every input is edge triggered, so an acknowledge returns 0x07.
- R2: Line n (0 to 7) drives primary input n. Line n (8 to 15) drives secondary input n-8. The vector is {base[7:3], input index}.
- R3: An edge-triggered input latches a request on a rising transition of its line, one clock after the transition. The request stays after the line falls, until that input is acknowledged.
- R4: A trigger-mode write (sel 2, bit set = level) takes effect only in bits 3 to 7 of the primary and bits 1, 2, 3, 4, 6 and 7 of the secondary. The other bits stay edge triggered. A level input follows its line, and acknowledging it does not clear it.
- R5: Among pending unmasked inputs, the winner is the first one met when scanning upward from input index `rot`, wrapping modulo 8. The offset is written with sel 3, and its reset value is 0.
- R6: A mask bit set to 1 (sel 0) keeps that input from raising `host_int`. A request latched while the input is masked is served once the mask bit is cleared.
- R7: An acknowledge while the primary winner is not input 2 returns the primary base with the winner index. It clears an edge-triggered request and sets that input in service.
- R8: When the primary winner is input 2 and the secondary has a resolvable request, the vector is the secondary base with the secondary winner. Both controllers set their winner in service.
- R9: When the primary winner is input 2 and the secondary has nothing resolvable, the vector is the secondary base with index 7. Only primary input 2 is set in service.
- R10: An acknowledge while `host_int` is low returns the primary base with index 7 and changes no state.
- R11: An in-service input blocks inputs of equal or lower priority. An end-of-service strobe clears the named unit's in-service bit.
- R12: `host_int` is high exactly when the primary controller has a pending unmasked request that is not blocked by its in-service bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_in | input | 16 | Interrupt request lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_unit | input | 1 | Configuration target: 0 primary, 1 secondary |
| cfg_sel | input | 2 | Register select: 0 mask, 1 vector base, 2 trigger mode, 3 rotation offset |
| cfg_wdata | input | 8 | Configuration write data |
| eoi_valid | input | 1 | End-of-service strobe |
| eoi_unit | input | 1 | End-of-service target unit: 0 primary, 1 secondary |
| eoi_idx | input | 3 | Input index whose in-service bit is cleared |
| ack | input | 1 | One-cycle interrupt acknowledge |
| vec_out | output | 8 | Resolved vector, valid during `ack` |
| host_int | output | 1 | Interrupt request to the host |

## Verification
The assertions check four things on every cycle:

- the low bits of a spurious vector;
- the secondary index taken through the cascade;
- an acknowledge landing in the in-service register, and an end-of-service strobe clearing it;
- edge requests never vanishing without an acknowledge, and level requests following their lines.

Only the bench scenarios can show the rest: the priority order under rotation, the effect of masking, in-service blocking, the trigger-mode write mask, and the spurious vector produced when the cascade edge stays latched after a secondary level line falls.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int UNIT_N = 8;
  localparam int IDX_W  = $clog2(UNIT_N);
  localparam int VEC_W  = 8;

  typedef enum logic [1:0] {
    CFG_MASK = 2'd0,
    CFG_BASE = 2'd1,
    CFG_TRIG = 2'd2,
    CFG_ROT  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/intc_rst_sync.sv
module intc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/intc_prio.sv
// Rotating priority search: the first set request met when scanning
// upward from index rot_i (modulo N) wins.
module intc_prio #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] req_i,
  input  logic [W-1:0] rot_i,
  output logic         hit_o,
  output logic [W-1:0] pos_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    hit_o = 1'b0;
    pos_o = '0;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[W'(k) + rot_i]) begin
        hit_o = 1'b1;
        pos_o = W'(k);
        idx_o = W'(k) + rot_i;
      end
    end
  end
endmodule

// File: rtl/intc_unit.sv
module intc_unit
  import intc_pkg::*;
#(
  parameter int           N          = UNIT_N,
  parameter int           W          = IDX_W,
  parameter int           VW         = VEC_W,
  parameter logic [N-1:0] TRIG_WMASK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  line_i,
  input  logic          cfg_we_i,
  input  cfg_sel_e      cfg_sel_i,
  input  logic [VW-1:0] cfg_data_i,
  input  logic          ack_i,
  input  logic          eoi_i,
  input  logic [W-1:0]  eoi_idx_i,
  output logic          int_o,
  output logic [W-1:0]  win_o,
  output logic [VW-1:0] vec_o
);
  localparam int BASE_W = VW - W;

  logic [N-1:0]      irr_q, irr_n, imr_q, imr_n, isr_q, isr_n;
  logic [N-1:0]      elcr_q, elcr_n, last_q;
  logic [BASE_W-1:0] base_q, base_n;
  logic [W-1:0]      rot_q, rot_n;

  logic          req_hit, isr_hit;
  logic [W-1:0]  req_pos, isr_pos, req_idx, isr_idx;
  logic [N-1:0]  rise, win_bit, eoi_bit;
  logic          take;

  intc_prio #(.N(N), .W(W)) u_req_prio (
    .req_i(irr_q & ~imr_q), .rot_i(rot_q),
    .hit_o(req_hit), .pos_o(req_pos), .idx_o(req_idx)
  );

  intc_prio #(.N(N), .W(W)) u_isr_prio (
    .req_i(isr_q), .rot_i(rot_q),
    .hit_o(isr_hit), .pos_o(isr_pos), .idx_o(isr_idx)
  );

  // Winner must outrank every in-service input.
  assign int_o = req_hit && (!isr_hit || (req_pos < isr_pos));
  assign win_o = req_idx;
  assign vec_o = {base_q, (int_o ? req_idx : {W{1'b1}})};

  assign take    = ack_i && int_o;
  assign win_bit = take  ? (N'(1) << req_idx)   : '0;
  assign eoi_bit = eoi_i ? (N'(1) << eoi_idx_i) : '0;
  assign rise    = line_i & ~last_q;

  always_comb begin
    irr_n  = (((irr_q & ~win_bit) | rise) & ~elcr_q) | (line_i & elcr_q);
    isr_n  = (isr_q & ~eoi_bit) | win_bit;
    imr_n  = imr_q;
    base_n = base_q;
    elcr_n = elcr_q;
    rot_n  = rot_q;
    if (cfg_we_i) begin
      unique case (cfg_sel_i)
        CFG_MASK: imr_n  = cfg_data_i[N-1:0];
        CFG_BASE: base_n = cfg_data_i[VW-1:W];
        CFG_TRIG: elcr_n = cfg_data_i[N-1:0] & TRIG_WMASK;
        CFG_ROT:  rot_n  = cfg_data_i[W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      isr_q  <= '0;
      imr_q  <= '1;
      elcr_q <= '0;
      last_q <= '0;
      base_q <= '0;
      rot_q  <= '0;
    end else begin
      irr_q  <= irr_n;
      isr_q  <= isr_n;
      imr_q  <= imr_n;
      elcr_q <= elcr_n;
      last_q <= line_i;
      base_q <= base_n;
      rot_q  <= rot_n;
    end
  end

  // R7: an accepted acknowledge puts its winner in service
  a_r7_ack_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> isr_q[$past(req_idx)]);

  // R11: end-of-service clears the named bit unless re-acknowledged at once
  a_r11_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !(take && (req_idx == eoi_idx_i))) |=> !isr_q[$past(eoi_idx_i)]);

  // R3: an edge request never disappears without an acknowledge
  a_r3_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> (($past(irr_q) & ~$past(elcr_q) & ~irr_q) == '0));

  // R4: level inputs follow their line
  a_r4_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irr_q & $past(elcr_q)) == ($past(line_i) & $past(elcr_q))));
endmodule

// File: rtl/cascade_intc.sv
module cascade_intc
  import intc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_in,
  input  logic        cfg_we,
  input  logic        cfg_unit,
  input  logic [1:0]  cfg_sel,
  input  logic [7:0]  cfg_wdata,
  input  logic        eoi_valid,
  input  logic        eoi_unit,
  input  logic [2:0]  eoi_idx,
  input  logic        ack,
  output logic [7:0]  vec_out,
  output logic        host_int
);
  localparam int              CASC_IN   = 2;
  localparam logic [IDX_W-1:0] CASC_IDX = IDX_W'(CASC_IN);
  localparam logic [UNIT_N-1:0] PRI_TRIG_WMASK = 8'hF8;
  localparam logic [UNIT_N-1:0] SEC_TRIG_WMASK = 8'hDE;

  logic                srst_n;
  logic                pri_int, sec_int;
  logic [IDX_W-1:0]    pri_win, sec_win;
  logic [VEC_W-1:0]    pri_vec, sec_vec;
  logic [UNIT_N-1:0]   pri_line;
  logic                casc_sel;
  cfg_sel_e            sel;

  assign sel = cfg_sel_e'(cfg_sel);

  intc_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  always_comb begin
    pri_line           = irq_in[UNIT_N-1:0];
    pri_line[CASC_IN]  = irq_in[CASC_IN] | sec_int;
  end

  assign casc_sel = pri_int && (pri_win == CASC_IDX);

  intc_unit #(.TRIG_WMASK(PRI_TRIG_WMASK)) u_pri (
    .clk(clk), .rst_n(srst_n), .line_i(pri_line),
    .cfg_we_i(cfg_we && !cfg_unit), .cfg_sel_i(sel), .cfg_data_i(cfg_wdata),
    .ack_i(ack), .eoi_i(eoi_valid && !eoi_unit), .eoi_idx_i(eoi_idx),
    .int_o(pri_int), .win_o(pri_win), .vec_o(pri_vec)
  );

  intc_unit #(.TRIG_WMASK(SEC_TRIG_WMASK)) u_sec (
    .clk(clk), .rst_n(srst_n), .line_i(irq_in[15:UNIT_N]),
    .cfg_we_i(cfg_we && cfg_unit), .cfg_sel_i(sel), .cfg_data_i(cfg_wdata),
    .ack_i(ack && casc_sel), .eoi_i(eoi_valid && eoi_unit), .eoi_idx_i(eoi_idx),
    .int_o(sec_int), .win_o(sec_win), .vec_o(sec_vec)
  );

  assign vec_out  = casc_sel ? sec_vec : pri_vec;
  assign host_int = pri_int;

  // R10: acknowledge with nothing resolvable yields index 7
  a_r10_spurious_idx: assert property (@(posedge clk) disable iff (!srst_n)
    (ack && !host_int) |-> (vec_out[IDX_W-1:0] == '1));

  // R8: cascade acknowledge reports the secondary winner
  a_r8_cascade_idx: assert property (@(posedge clk) disable iff (!srst_n)
    (ack && casc_sel && sec_int) |-> (vec_out[IDX_W-1:0] == sec_win));
endmodule

// File: tb/cascade_intc_tb.sv
module cascade_intc_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_in;
  logic        cfg_we, cfg_unit;
  logic [1:0]  cfg_sel;
  logic [7:0]  cfg_wdata;
  logic        eoi_valid, eoi_unit;
  logic [2:0]  eoi_idx;
  logic        ack;
  logic [7:0]  vec_out;
  logic        host_int;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cascade_intc u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .cfg_we(cfg_we), .cfg_unit(cfg_unit), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .eoi_valid(eoi_valid), .eoi_unit(eoi_unit), .eoi_idx(eoi_idx),
    .ack(ack), .vec_out(vec_out), .host_int(host_int)
  );

  // {line[3:0], expected vector[7:0]}, bases 0x20 / 0x70
  localparam logic [11:0] TBL [0:15] = '{
    12'h020, 12'h121, 12'h277, 12'h323, 12'h424, 12'h525, 12'h626, 12'h727,
    12'h870, 12'h971, 12'hA72, 12'hB73, 12'hC74, 12'hD75, 12'hE76, 12'hF77
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfg(input logic unit, input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_unit = unit; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic eoi(input logic unit, input logic [2:0] idx);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_unit = unit; eoi_idx = idx;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic eoi_all();
    for (int u = 0; u < 2; u++)
      for (int k = 0; k < 8; k++) eoi(u[0], k[2:0]);
  endtask

  task automatic do_ack(input string req, input logic [7:0] exp);
    @(negedge clk);
    ack = 1'b1;
    #1;
    check(req, vec_out, exp);
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic host(input string req, input logic exp);
    @(negedge clk);
    #1;
    check(req, {7'd0, host_int}, {7'd0, exp});
  endtask

  task automatic pulse(input logic [15:0] m);
    @(negedge clk);
    irq_in = irq_in | m;
    @(negedge clk);
    irq_in = irq_in & ~m;
  endtask

  initial begin
    rst_n = 1'b0; irq_in = '0; cfg_we = 1'b0; cfg_unit = 1'b0; cfg_sel = '0;
    cfg_wdata = '0; eoi_valid = 1'b0; eoi_unit = 1'b0; eoi_idx = '0; ack = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    #1;
    check("R1 host low after reset", {7'd0, host_int}, 8'd0);
    do_ack("R1 reset base, R10 spurious", 8'h07);

    cfg(1'b0, 2'd1, 8'h20);
    cfg(1'b1, 2'd1, 8'h70);
    cfg(1'b0, 2'd0, 8'h00);
    cfg(1'b1, 2'd0, 8'h00);
    do_ack("R10 spurious primary base", 8'h27);
    host("R10 no state change", 1'b0);

    // Table: each line alone (R2, R7, R8, R9)
    for (int e = 0; e < 16; e++) begin
      pulse(16'd1 << TBL[e][11:8]);
      tick(2);
      #1;
      check("R3/R12 host after request", {7'd0, host_int}, 8'd1);
      do_ack("R2 line vector", TBL[e][7:0]);
      eoi_all();
      host("R11 idle after end-of-service", 1'b0);
    end

    // R5 fixed priority
    pulse(16'h0028);
    tick(1);
    do_ack("R5 lowest index first", 8'h23);
    eoi(1'b0, 3'd3);
    do_ack("R5 next request", 8'h25);
    eoi(1'b0, 3'd5);

    // R5 rotation offset 4
    cfg(1'b0, 2'd3, 8'h04);
    pulse(16'h0042);
    tick(1);
    do_ack("R5 rotated order", 8'h26);
    eoi(1'b0, 3'd6);
    do_ack("R5 rotated wrap", 8'h21);
    eoi(1'b0, 3'd1);
    cfg(1'b0, 2'd3, 8'h00);

    // R6 masking
    cfg(1'b0, 2'd0, 8'h01);
    pulse(16'h0001);
    tick(1);
    host("R6 masked input silent", 1'b0);
    cfg(1'b0, 2'd0, 8'h00);
    host("R6 latched request after unmask", 1'b1);
    do_ack("R6 unmasked vector", 8'h20);
    eoi(1'b0, 3'd0);
    cfg(1'b1, 2'd0, 8'hFF);
    pulse(16'h1000);
    tick(2);
    host("R6 secondary masked", 1'b0);
    cfg(1'b1, 2'd0, 8'h00);
    tick(1);
    host("R6 secondary unmasked", 1'b1);
    do_ack("R6/R8 secondary vector", 8'h74);
    eoi_all();

    // R11 in-service blocking
    pulse(16'h0010);
    tick(1);
    do_ack("R11 first service", 8'h24);
    pulse(16'h0040);
    tick(1);
    host("R11 lower priority blocked", 1'b0);
    pulse(16'h0002);
    host("R11 higher priority passes", 1'b1);
    do_ack("R11 nested vector", 8'h21);
    eoi(1'b0, 3'd1);
    host("R11 still blocked by outer", 1'b0);
    eoi(1'b0, 3'd4);
    host("R11 released after end-of-service", 1'b1);
    do_ack("R11 pending lower served", 8'h26);
    eoi(1'b0, 3'd6);

    // R4 trigger mode, primary
    cfg(1'b0, 2'd2, 8'hFF);
    @(negedge clk); irq_in[3] = 1'b1;
    host("R4 level asserts", 1'b1);
    do_ack("R4 level vector", 8'h23);
    host("R11 level blocked in service", 1'b0);
    eoi(1'b0, 3'd3);
    host("R4 level not cleared by ack", 1'b1);
    @(negedge clk); irq_in[3] = 1'b0;
    host("R4 level follows line low", 1'b0);
    pulse(16'h0001);
    tick(1);
    host("R4 bit 0 forced edge", 1'b1);
    do_ack("R4 forced edge vector", 8'h20);
    eoi(1'b0, 3'd0);
    cfg(1'b0, 2'd2, 8'h00);

    // R4/R9 secondary level line 9, cascade edge stays latched
    cfg(1'b1, 2'd2, 8'hFF);
    @(negedge clk); irq_in[9] = 1'b1;
    tick(3);
    irq_in[9] = 1'b0;
    tick(2);
    #1;
    check("R9 cascade edge latched", {7'd0, host_int}, 8'd1);
    do_ack("R9 secondary spurious", 8'h77);
    eoi(1'b0, 3'd2);
    host("R9 idle after", 1'b0);
    pulse(16'h0100);
    tick(2);
    host("R4 secondary bit 0 forced edge", 1'b1);
    do_ack("R4 secondary edge vector", 8'h70);
    eoi_all();
    cfg(1'b1, 2'd2, 8'h00);
    host("R12 idle at end", 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule